// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit works out where the program counter goes next after a control-transfer instruction. Each request carries an instruction class code, the address of the next sequential instruction, and the operand bytes. It also carries the accumulator, the data pointer, the carry flag, a pair of compare operands, a loop counter value and an address popped from the stack. One clock edge later the unit returns four things: the next program counter, a taken flag, the return address to push for calls, and the side results the condition produced (a new carry value and a decremented counter).

The unit handles several kinds of transfer. Relative jumps and all conditional forms add a signed 8-bit displacement to the address of the following instruction. Long forms load a full 16-bit target. In-page forms keep the upper five bits of the following instruction's address and replace the lower eleven. The indirect form adds the accumulator to the data pointer. A return resumes at the popped address. The stack itself and interrupt priority handling live outside the unit.

Top module: `branch_target_unit`

## Requirements
- R1: A clock edge with `rst_n` low clears `out_valid`, `out_taken`, `out_push_en`, `out_carry_we` and `out_carry`, and sets `out_next_pc` to 0.
- R2: Results appear on the clock edge after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid`, `out_taken`, `out_push_en` and `out_carry_we` are all 0.
- R3: The relative target is `in_pc_next` plus `in_rel` read as a signed byte, modulo 65536. Class 1 (short jump) always takes it.
- R4: Class 2 (long jump) and class 5 (long call) branch to `{in_byte2, in_byte3}`, with `in_byte2` as the high byte.
- R5: Class 3 (page jump) and class 4 (page call) branch to `{in_pc_next[15:11], in_page_bits, in_byte2}`. The upper five bits of the result therefore equal those of `in_pc_next`.
- R6: Class 6 (indirect jump) branches to `in_dptr` plus the zero-extended `in_acc`, modulo 65536.
- R7: Class 7 branches to the relative target when `in_acc` is zero, and class 8 when it is nonzero. Class 9 branches when `in_carry` is 1, and class 10 when it is 0.
- R8: Class 11 (compare) branches to the relative target when `in_cmp_lhs` differs from `in_cmp_rhs`. It raises `out_carry_we`, with `out_carry` = 1 exactly when `in_cmp_lhs` is less than `in_cmp_rhs` as unsigned numbers.
- R9: Class 12 (decrement) sets `out_count` to `in_count` minus 1 modulo 256. It branches to the relative target exactly when that result is nonzero.
- R10: Classes 4 and 5 raise `out_push_en`, with `out_push_addr` equal to `in_pc_next`. Class 13 (return) branches to `in_pop_addr`. No other class raises `out_push_en`.
- R11: Whenever `out_taken` is 0 on a valid result, `out_next_pc` equals `in_pc_next`. Class 0 and the unused codes 14 and 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_class | input | 4 | Instruction class code |
| in_pc_next | input | 16 | Address of the next sequential instruction |
| in_byte2 | input | 8 | Second instruction byte |
| in_byte3 | input | 8 | Third instruction byte |
| in_page_bits | input | 3 | Upper three bits of an in-page address, taken from the opcode byte |
| in_rel | input | 8 | Signed relative displacement |
| in_acc | input | 8 | Accumulator value |
| in_dptr | input | 16 | Data pointer value |
| in_carry | input | 1 | Current carry flag |
| in_cmp_lhs | input | 8 | First compare operand |
| in_cmp_rhs | input | 8 | Second compare operand |
| in_count | input | 8 | Operand to decrement and test |
| in_pop_addr | input | 16 | Return address popped from the stack |
| out_valid | output | 1 | Result present |
| out_next_pc | output | 16 | Next program counter |
| out_taken | output | 1 | Transfer taken |
| out_push_en | output | 1 | Return address must be pushed |
| out_push_addr | output | 16 | Return address to push |
| out_carry_we | output | 1 | Carry flag must be written |
| out_carry | output | 1 | New carry value |
| out_count | output | 8 | Decremented operand |

## Verification
Every path through the unit ends in the single output register, so a wrong target, a wrong condition or a bad sign extension shows up on `out_next_pc` or `out_taken` on the first edge after the offending request. A displacement or page splice that is off by a bit appears as a target differing only in the high byte or in bits 15 to 11. This is why the vectors include displacements of -128 and +127 next to the wrap points of the address space. The compare carry uses operands that disagree under signed and unsigned readings. The decrement test starts from 0, 1 and 2, so that an off-by-one or an inverted test changes the taken flag at once.

// File: rtl/bt_pkg.sv
// Shared types for the branch target unit.
// Assumes the class code is four bits wide; codes 14 and 15 are unused.
package bt_pkg;

    typedef enum logic [3:0] {
        BR_SEQ       = 4'd0,
        BR_SHORT     = 4'd1,
        BR_LONG      = 4'd2,
        BR_PAGE      = 4'd3,
        BR_PAGE_CALL = 4'd4,
        BR_LONG_CALL = 4'd5,
        BR_INDIRECT  = 4'd6,
        BR_ACC_ZERO  = 4'd7,
        BR_ACC_NZ    = 4'd8,
        BR_CY_SET    = 4'd9,
        BR_CY_CLR    = 4'd10,
        BR_CMP_NE    = 4'd11,
        BR_DEC_NZ    = 4'd12,
        BR_RETURN    = 4'd13,
        BR_RSVD_E    = 4'd14,
        BR_RSVD_F    = 4'd15
    } br_class_e;

    // True for the classes that branch to the relative target when their condition holds.
    function automatic logic is_relative(input br_class_e c);
        return (c == BR_SHORT)  || (c == BR_ACC_ZERO) || (c == BR_ACC_NZ) ||
               (c == BR_CY_SET) || (c == BR_CY_CLR)   || (c == BR_CMP_NE) ||
               (c == BR_DEC_NZ);
    endfunction

    // True for the classes that push a return address.
    function automatic logic is_call(input br_class_e c);
        return (c == BR_PAGE_CALL) || (c == BR_LONG_CALL);
    endfunction

endpackage

// File: rtl/bt_rel_adder.sv
// Adds a signed displacement to a base address, wrapping modulo 2**PC_W.
// Assumes OFS_W <= PC_W; the generate picks sign extension or a plain add.
module bt_rel_adder #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 8
) (
    input  logic [PC_W-1:0]  base,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  sum
);
    localparam int EXT_W = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_ext;

    generate
        if (EXT_W > 0) begin : g_sext
            // Replicate the sign bit into the upper part of the addend.
            always_comb ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        end else begin : g_same
            // Displacement already spans the full address width.
            always_comb ofs_ext = ofs;
        end
    endgenerate

    // Modular add; the carry out of the top bit is dropped on purpose.
    always_comb sum = base + ofs_ext;

endmodule

// File: rtl/bt_cond_eval.sv
// Evaluates the branch condition for a class and produces the compare carry
// and the decremented counter. Unconditional transfer classes report true.
// Assumes operands are unsigned DATA_W-bit values.
module bt_cond_eval
    import bt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  br_class_e         cls,
    input  logic [DATA_W-1:0] acc,
    input  logic              carry,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic [DATA_W-1:0] count,
    output logic              cond_met,
    output logic              carry_we,
    output logic              carry_out,
    output logic [DATA_W-1:0] count_dec
);
    localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [DATA_W:0] cmp_diff;
    logic            cmp_ne;

    // Unsigned subtract: the extra top bit is the borrow, i.e. lhs < rhs.
    always_comb begin
        cmp_diff  = {1'b0, lhs} - {1'b0, rhs};
        cmp_ne    = (cmp_diff[DATA_W-1:0] != ZERO);
        carry_out = cmp_diff[DATA_W];
        carry_we  = (cls == BR_CMP_NE);
    end

    // Decrement with wrap from zero to all ones.
    always_comb count_dec = count - ONE;

    // Select the condition that governs the chosen class.
    always_comb begin
        unique case (cls)
            BR_SHORT, BR_LONG, BR_PAGE, BR_PAGE_CALL,
            BR_LONG_CALL, BR_INDIRECT, BR_RETURN: cond_met = 1'b1;
            BR_ACC_ZERO:                          cond_met = (acc == ZERO);
            BR_ACC_NZ:                            cond_met = (acc != ZERO);
            BR_CY_SET:                            cond_met = carry;
            BR_CY_CLR:                            cond_met = ~carry;
            BR_CMP_NE:                            cond_met = cmp_ne;
            BR_DEC_NZ:                            cond_met = (count_dec != ZERO);
            default:                              cond_met = 1'b0;
        endcase
    end

endmodule

// File: rtl/bt_target_sel.sv
// Builds every candidate target and picks the next program counter.
// Assumes PC_W = 2*DATA_W and DATA_W < PAGE_W < PC_W. The page base is taken
// from the address of the following instruction.
module bt_target_sel
    import bt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 11
) (
    input  br_class_e                 cls,
    input  logic                      cond_met,
    input  logic [PC_W-1:0]           pc_next,
    input  logic [DATA_W-1:0]         byte2,
    input  logic [DATA_W-1:0]         byte3,
    input  logic [PAGE_W-DATA_W-1:0]  page_bits,
    input  logic [DATA_W-1:0]         rel,
    input  logic [DATA_W-1:0]         acc,
    input  logic [PC_W-1:0]           dptr,
    input  logic [PC_W-1:0]           pop_addr,
    output logic [PC_W-1:0]           next_pc,
    output logic                      taken,
    output logic                      push_en
);
    localparam int ZEXT_W = PC_W - DATA_W;

    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] long_tgt;
    logic [PC_W-1:0] page_tgt;
    logic [PC_W-1:0] ind_tgt;
    logic [PC_W-1:0] tgt;

    bt_rel_adder #(
        .PC_W  (PC_W),
        .OFS_W (DATA_W)
    ) i_rel_add (
        .base (pc_next),
        .ofs  (rel),
        .sum  (rel_tgt)
    );

    // Assemble the fixed-form targets: full address, in-page splice, indexed.
    always_comb begin
        long_tgt = {byte2, byte3};
        page_tgt = {pc_next[PC_W-1:PAGE_W], page_bits, byte2};
        ind_tgt  = dptr + {{ZEXT_W{1'b0}}, acc};
    end

    // Choose the candidate that belongs to the class.
    always_comb begin
        if (is_relative(cls)) begin
            tgt = rel_tgt;
        end else begin
            unique case (cls)
                BR_LONG, BR_LONG_CALL: tgt = long_tgt;
                BR_PAGE, BR_PAGE_CALL: tgt = page_tgt;
                BR_INDIRECT:           tgt = ind_tgt;
                BR_RETURN:             tgt = pop_addr;
                default:               tgt = pc_next;
            endcase
        end
    end

    // Fall through to the sequential address when the condition fails.
    always_comb begin
        taken   = cond_met;
        next_pc = cond_met ? tgt : pc_next;
        push_en = is_call(cls);
    end

endmodule

// File: rtl/branch_target_unit.sv
// Top of the branch target unit: decodes the class, evaluates the condition,
// selects the target and registers every result once.
// Assumes a request is held for one cycle with in_valid high; the results
// follow on the next clock edge.
module branch_target_unit
    import bt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [3:0]               in_class,
    input  logic [PC_W-1:0]          in_pc_next,
    input  logic [DATA_W-1:0]        in_byte2,
    input  logic [DATA_W-1:0]        in_byte3,
    input  logic [PAGE_W-DATA_W-1:0] in_page_bits,
    input  logic [DATA_W-1:0]        in_rel,
    input  logic [DATA_W-1:0]        in_acc,
    input  logic [PC_W-1:0]          in_dptr,
    input  logic                     in_carry,
    input  logic [DATA_W-1:0]        in_cmp_lhs,
    input  logic [DATA_W-1:0]        in_cmp_rhs,
    input  logic [DATA_W-1:0]        in_count,
    input  logic [PC_W-1:0]          in_pop_addr,
    output logic                     out_valid,
    output logic [PC_W-1:0]          out_next_pc,
    output logic                     out_taken,
    output logic                     out_push_en,
    output logic [PC_W-1:0]          out_push_addr,
    output logic                     out_carry_we,
    output logic                     out_carry,
    output logic [DATA_W-1:0]        out_count
);
    br_class_e         cls;
    logic              cond_met;
    logic              carry_we;
    logic              carry_val;
    logic [DATA_W-1:0] count_dec;
    logic [PC_W-1:0]   next_pc;
    logic              taken;
    logic              push_en;

    // Interpret the raw class code as the shared enumeration.
    always_comb cls = br_class_e'(in_class);

    bt_cond_eval #(
        .DATA_W (DATA_W)
    ) i_cond (
        .cls       (cls),
        .acc       (in_acc),
        .carry     (in_carry),
        .lhs       (in_cmp_lhs),
        .rhs       (in_cmp_rhs),
        .count     (in_count),
        .cond_met  (cond_met),
        .carry_we  (carry_we),
        .carry_out (carry_val),
        .count_dec (count_dec)
    );

    bt_target_sel #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) i_sel (
        .cls       (cls),
        .cond_met  (cond_met),
        .pc_next   (in_pc_next),
        .byte2     (in_byte2),
        .byte3     (in_byte3),
        .page_bits (in_page_bits),
        .rel       (in_rel),
        .acc       (in_acc),
        .dptr      (in_dptr),
        .pop_addr  (in_pop_addr),
        .next_pc   (next_pc),
        .taken     (taken),
        .push_en   (push_en)
    );

    // Output register; strobes are qualified by the request valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_next_pc   <= '0;
            out_taken     <= 1'b0;
            out_push_en   <= 1'b0;
            out_push_addr <= '0;
            out_carry_we  <= 1'b0;
            out_carry     <= 1'b0;
            out_count     <= '0;
        end else begin
            out_valid    <= in_valid;
            out_taken    <= in_valid & taken;
            out_push_en  <= in_valid & push_en;
            out_carry_we <= in_valid & carry_we;
            if (in_valid) begin
                out_next_pc   <= next_pc;
                out_push_addr <= in_pc_next;
                out_carry     <= carry_we & carry_val;
                out_count     <= count_dec;
            end
        end
    end

endmodule

// File: rtl/bt_checker.sv
// Temporal checks on the branch target unit ports, bound to every instance.
module bt_checker
    import bt_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_class,
    input logic [PC_W-1:0]   in_pc_next,
    input logic [DATA_W-1:0] in_cmp_lhs,
    input logic [DATA_W-1:0] in_cmp_rhs,
    input logic              out_valid,
    input logic [PC_W-1:0]   out_next_pc,
    input logic              out_taken,
    input logic              out_push_en,
    input logic [PC_W-1:0]   out_push_addr,
    input logic              out_carry_we,
    input logic              out_carry,
    input logic [DATA_W-1:0] out_count
);
    AST_VALID_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_taken && !out_push_en && !out_carry_we)); // R2

    AST_SEQ_IF_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> out_next_pc == $past(in_pc_next)); // R11

    AST_PUSH_RETURN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_push_en |-> (out_push_addr == $past(in_pc_next) &&
                         ($past(in_class) == BR_PAGE_CALL || $past(in_class) == BR_LONG_CALL))); // R10

    AST_CMP_CARRY_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_carry_we |-> out_carry == ($past(in_cmp_lhs) < $past(in_cmp_rhs))); // R8

    AST_PAGE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(in_class) == BR_PAGE || $past(in_class) == BR_PAGE_CALL))
        |-> out_next_pc[PC_W-1:PAGE_W] == $past(in_pc_next[PC_W-1:PAGE_W])); // R5

    AST_DEC_TEST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_class) == BR_DEC_NZ) |-> out_taken == (out_count != '0)); // R9

endmodule

bind branch_target_unit bt_checker #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
) i_bt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_class      (in_class),
    .in_pc_next    (in_pc_next),
    .in_cmp_lhs    (in_cmp_lhs),
    .in_cmp_rhs    (in_cmp_rhs),
    .out_valid     (out_valid),
    .out_next_pc   (out_next_pc),
    .out_taken     (out_taken),
    .out_push_en   (out_push_en),
    .out_push_addr (out_push_addr),
    .out_carry_we  (out_carry_we),
    .out_carry     (out_carry),
    .out_count     (out_count)
);

// File: tb/test_branch_target_unit.sv
`timescale 1ns/1ps
module test_branch_target_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_class;
    logic [15:0] in_pc_next;
    logic [7:0]  in_byte2;
    logic [7:0]  in_byte3;
    logic [2:0]  in_page_bits;
    logic [7:0]  in_rel;
    logic [7:0]  in_acc;
    logic [15:0] in_dptr;
    logic        in_carry;
    logic [7:0]  in_cmp_lhs;
    logic [7:0]  in_cmp_rhs;
    logic [7:0]  in_count;
    logic [15:0] in_pop_addr;
    logic        out_valid;
    logic [15:0] out_next_pc;
    logic        out_taken;
    logic        out_push_en;
    logic [15:0] out_push_addr;
    logic        out_carry_we;
    logic        out_carry;
    logic [7:0]  out_count;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    branch_target_unit i_branch_target_unit (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_class (in_class),
        .in_pc_next (in_pc_next), .in_byte2 (in_byte2), .in_byte3 (in_byte3),
        .in_page_bits (in_page_bits), .in_rel (in_rel), .in_acc (in_acc),
        .in_dptr (in_dptr), .in_carry (in_carry), .in_cmp_lhs (in_cmp_lhs),
        .in_cmp_rhs (in_cmp_rhs), .in_count (in_count), .in_pop_addr (in_pop_addr),
        .out_valid (out_valid), .out_next_pc (out_next_pc), .out_taken (out_taken),
        .out_push_en (out_push_en), .out_push_addr (out_push_addr),
        .out_carry_we (out_carry_we), .out_carry (out_carry), .out_count (out_count)
    );

    typedef struct packed {
        logic [3:0]  cls;
        logic [15:0] pc;
        logic [7:0]  b2;
        logic [7:0]  b3;
        logic [2:0]  pg;
        logic [7:0]  rel;
        logic [7:0]  acc;
        logic [15:0] dptr;
        logic        cy;
        logic [7:0]  lhs;
        logic [7:0]  rhs;
        logic [7:0]  cnt;
        logic [15:0] pop;
        logic [15:0] xpc;
        logic        xtk;
        logic        xpush;
        logic        xcwe;
        logic        xcy;
        logic [7:0]  xcnt;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [0:NV-1] = '{
        // R3 short jump forward, backward, -128 with wrap below zero, +127 with wrap past top
        '{4'd1, 16'h1000, 8'h00, 8'h00, 3'd0, 8'h10, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h1010, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd1, 16'h1000, 8'h00, 8'h00, 3'd0, 8'hF0, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0FF0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd1, 16'h0005, 8'h00, 8'h00, 3'd0, 8'h80, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'hFF85, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd1, 16'hFFF0, 8'h00, 8'h00, 3'd0, 8'h7F, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h006F, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        // R4 long jump
        '{4'd2, 16'h0010, 8'hAB, 8'hCD, 3'd0, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'hABCD, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        // R5 page jump, R5/R10 page call
        '{4'd3, 16'h37FE, 8'h23, 8'h00, 3'd7, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h3723, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd4, 16'h0802, 8'hFF, 8'h00, 3'd2, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0AFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        // R4/R10 long call
        '{4'd5, 16'h4567, 8'h12, 8'h34, 3'd0, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
        // R6 indirect, with and without wrap
        '{4'd6, 16'h0020, 8'h00, 8'h00, 3'd0, 8'h00, 8'h80, 16'hFFC0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd6, 16'h0020, 8'h00, 8'h00, 3'd0, 8'h00, 8'h05, 16'h2000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h2005, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        // R7 accumulator zero / nonzero
        '{4'd7, 16'h0100, 8'h00, 8'h00, 3'd0, 8'h04, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0104, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd7, 16'h0100, 8'h00, 8'h00, 3'd0, 8'h04, 8'h01, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd8, 16'h0200, 8'h00, 8'h00, 3'd0, 8'hFE, 8'h40, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h01FE, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd8, 16'h0200, 8'h00, 8'h00, 3'd0, 8'hFE, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        // R7 carry set / clear
        '{4'd9,  16'h0300, 8'h00, 8'h00, 3'd0, 8'h02, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0302, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd9,  16'h0300, 8'h00, 8'h00, 3'd0, 8'h02, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd10, 16'h0300, 8'h00, 8'h00, 3'd0, 8'h02, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0302, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd10, 16'h0300, 8'h00, 8'h00, 3'd0, 8'h02, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        // R8 compare: less, greater, equal, signed-vs-unsigned
        '{4'd11, 16'h0400, 8'h00, 8'h00, 3'd0, 8'h08, 8'h00, 16'h0000, 1'b0, 8'h10, 8'h20, 8'h00, 16'h0000, 16'h0408, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
        '{4'd11, 16'h0400, 8'h00, 8'h00, 3'd0, 8'h08, 8'h00, 16'h0000, 1'b1, 8'h20, 8'h10, 8'h00, 16'h0000, 16'h0408, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
        '{4'd11, 16'h0400, 8'h00, 8'h00, 3'd0, 8'h08, 8'h00, 16'h0000, 1'b1, 8'h55, 8'h55, 8'h00, 16'h0000, 16'h0400, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        '{4'd11, 16'h0400, 8'h00, 8'h00, 3'd0, 8'h08, 8'h00, 16'h0000, 1'b0, 8'h7F, 8'h80, 8'h00, 16'h0000, 16'h0408, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
        // R9 decrement from 2, 1 and 0
        '{4'd12, 16'h0500, 8'h00, 8'h00, 3'd0, 8'hFC, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h02, 16'h0000, 16'h04FC, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},
        '{4'd12, 16'h0500, 8'h00, 8'h00, 3'd0, 8'hFC, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h01, 16'h0000, 16'h0500, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd12, 16'h0500, 8'h00, 8'h00, 3'd0, 8'hFC, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h04FC, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
        // R10 return
        '{4'd13, 16'h0600, 8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 16'hBEEF, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        // R11 sequential and unused code
        '{4'd0,  16'h1234, 8'hAA, 8'hBB, 3'd5, 8'h40, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00, 16'hFFFF, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{4'd15, 16'h2222, 8'hAA, 8'hBB, 3'd5, 8'h40, 8'h00, 16'h0000, 1'b1, 8'h01, 8'h02, 8'h00, 16'hFFFF, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_class     = v.cls;
        in_pc_next   = v.pc;
        in_byte2     = v.b2;
        in_byte3     = v.b3;
        in_page_bits = v.pg;
        in_rel       = v.rel;
        in_acc       = v.acc;
        in_dptr      = v.dptr;
        in_carry     = v.cy;
        in_cmp_lhs   = v.lhs;
        in_cmp_rhs   = v.rhs;
        in_count     = v.cnt;
        in_pop_addr  = v.pop;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        drive(VECS[7]);
        repeat (3) @(negedge clk);

        // R1: reset state despite a call request being presented
        chk("R1 out_valid",    32'(out_valid),    32'd0);
        chk("R1 out_taken",    32'(out_taken),    32'd0);
        chk("R1 out_push_en",  32'(out_push_en),  32'd0);
        chk("R1 out_carry_we", 32'(out_carry_we), 32'd0);
        chk("R1 out_carry",    32'(out_carry),    32'd0);
        chk("R1 out_next_pc",  32'(out_next_pc),  32'd0);

        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            chk("R2 out_valid",            32'(out_valid),   32'd1);
            chk("R3-R11 next pc",          32'(out_next_pc), 32'(VECS[i].xpc));
            chk("R7/R8/R9/R11 taken",      32'(out_taken),   32'(VECS[i].xtk));
            chk("R10 push strobe",         32'(out_push_en), 32'(VECS[i].xpush));
            if (VECS[i].xpush)
                chk("R10 push address", 32'(out_push_addr), 32'(VECS[i].pc));
            chk("R8 carry write",          32'(out_carry_we), 32'(VECS[i].xcwe));
            if (VECS[i].xcwe)
                chk("R8 carry value", 32'(out_carry), 32'(VECS[i].xcy));
            if (VECS[i].cls == 4'd12)
                chk("R9 decremented count", 32'(out_count), 32'(VECS[i].xcnt));
        end

        // R2: idle cycle with a call presented must raise nothing
        drive(VECS[7]);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle out_valid",    32'(out_valid),    32'd0);
        chk("R2 idle out_push_en",  32'(out_push_en),  32'd0);
        chk("R2 idle out_taken",    32'(out_taken),    32'd0);
        drive(VECS[18]);
        @(negedge clk);
        chk("R2 idle out_carry_we", 32'(out_carry_we), 32'd0);

        // R1: reset in the middle of a stream clears a pending result
        in_valid = 1'b1;
        drive(VECS[25]);
        @(negedge clk);
        chk("R10 return target before reset", 32'(out_next_pc), 32'h0000BEEF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-stream out_valid",   32'(out_valid),   32'd0);
        chk("R1 mid-stream out_next_pc", 32'(out_next_pc), 32'd0);
        chk("R1 mid-stream out_taken",   32'(out_taken),   32'd0);
        rst_n = 1'b1;

        // R3: back-to-back requests, each result on its own edge
        drive(VECS[0]);
        @(negedge clk);
        chk("R3 back-to-back first", 32'(out_next_pc), 32'h00001010);
        drive(VECS[2]);
        @(negedge clk);
        chk("R3 back-to-back second", 32'(out_next_pc), 32'h0000FF85);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule